// File: doc/BRIEF.md
# JTAG Debug Register Access Controller

This block sits behind an IEEE 1149.1 test access port and gives a debug tool read and write access to up to 128 internal debug registers. It contains its own TAP state machine, a 4-bit instruction register and the data-register scan paths. While the instruction register holds the access opcode, every register access uses two DR-scan passes. The first pass shifts in an 8-bit command: a read/write flag in bit 0 and a 7-bit register index above it. The second pass moves 32 bits of data in or out.

A small sequencer decides which of the two passes the next DR scan is. It has three states: idle, command select and data access. The register side is a plain parallel port. The block drives an address and, for a write, a data word with a one-cycle write strobe. For a read it raises a one-cycle read strobe and samples the returned word in the same cycle. When any other instruction is loaded, the DR path is a single bypass bit.

Top module: `jtag_dbg_regacc`

## Requirements
- R1: The TAP state advances on each rising `tck` according to `tms`, following the standard 16-state diagram. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state, and `trst_n` low forces Test-Logic-Reset at once.
- R2: The instruction register is 4 bits wide and is shifted LSB first. Capture-IR loads 4'b0001, so the first four bits out of an IR scan are 1,0,0,0. Test-Logic-Reset loads the bypass opcode 4'b1111, and Update-IR loads the shifted value.
- R3: While the instruction register holds any value other than the access opcode (default 4'b1000), the DR path is a 1-bit bypass register that captures 0. An N-bit DR scan therefore returns a 0 followed by the input delayed by one bit, and it causes no register strobe.
- R4: The sequencer is forced to idle by Test-Logic-Reset or by the access opcode not being in the instruction register. Whenever the opcode is in force, the sequencer enters command select. An Update-IR with the opcode in force returns it to command select from any state.
- R5: In command select, a DR scan shifts an 8-bit command LSB first and captures all zeros. Command bit 0 is 1 for a write and 0 for a read, and bits 7:1 are the register index. Update-DR latches the command and moves the sequencer to data access.
- R6: In data access, Update-DR returns the sequencer to command select, so commands and data passes alternate.
- R7: For a read command, the Capture-DR cycle of the data pass drives `reg_rd` high for exactly one cycle, with `reg_addr` equal to the index. The 32-bit `reg_rdata` is loaded and shifted out LSB first on `tdo`.
- R8: For a write command, the 32 bits shifted in (LSB first) appear on `reg_wdata`, with `reg_addr` set to the index, while `reg_wr` pulses for exactly one cycle at Update-DR. A read access never raises `reg_wr`, and a write access never raises `reg_rd`.
- R9: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is high exactly while the TAP is in Shift-IR or Shift-DR and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | High while `tdo` carries shifted data |
| reg_addr | output | 7 | Index of the selected debug register |
| reg_wdata | output | 32 | Write data for the selected register |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data of the register at `reg_addr`, combinational |

## Verification
On a single rising edge at Update-DR, the block both fires the register write strobe and sends the sequencer from data access back to command select. The next command pass must therefore see a freshly idle command path while the register file absorbs the write. The bench provokes this by running every register index back to back: each write is followed directly by the next command scan, and later each read follows a write without any gap. A bench-side register model and independently computed data patterns judge the result. Every read must return the arithmetic pattern for its index, strobe counts must rise by exactly one per access, and the command pass after each write must capture zeros.

// File: rtl/dra_pkg.sv
package dra_pkg;

   typedef enum logic [3:0] {
      TS_TLR,    TS_RTI,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_st_e;

   typedef enum logic [1:0] {
      CS_IDLE,
      CS_SELECT,
      CS_ACCESS
   } seq_st_e;

endpackage

// File: rtl/dra_tap.sv
module dra_tap
   import dra_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   tap_st_e nxt;

   always_comb begin
      case (st)
         TS_TLR:    nxt = tms ? TS_TLR    : TS_RTI;
         TS_RTI:    nxt = tms ? TS_SEL_DR : TS_RTI;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_RTI;
         TS_SEL_IR: nxt = tms ? TS_TLR    : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_RTI;
         default:   nxt = TS_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= TS_TLR;
      else         st <= nxt;
   end

   AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_TLR && tms) |=> (st == TS_TLR)); // R1

   AST_SHIFT_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_SHF_DR && tms) |=> (st == TS_EX1_DR)); // R1

endmodule

// File: rtl/dra_ir.sv
module dra_ir
   import dra_pkg::*;
#(
   parameter int IR_W = 4
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_st_e         st,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_lsb
);

   localparam logic [IR_W-1:0] IR_BYP = '1;
   localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-1){1'b0}}, 1'b1};

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= IR_CAP;
         ir_q  <= IR_BYP;
      end else begin
         case (st)
            TS_TLR:    ir_q  <= IR_BYP;
            TS_CAP_IR: ir_sh <= IR_CAP;
            TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            TS_UPD_IR: ir_q  <= ir_sh;
            default:   ;
         endcase
      end
   end

   assign ir_lsb = ir_sh[0];

   AST_IR_TLR: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_TLR) |=> (ir_q == IR_BYP)); // R2

   AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_CAP_IR) |=> (ir_lsb == 1'b1)); // R2

endmodule

// File: rtl/dra_seq.sv
module dra_seq
   import dra_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  tap_st_e st,
   input  logic    en,
   output seq_st_e cs
);

   seq_st_e nxt;

   always_comb begin
      nxt = cs;
      if (st == TS_TLR || !en)
         nxt = CS_IDLE;
      else if (st == TS_UPD_IR || cs == CS_IDLE)
         nxt = CS_SELECT;
      else if (st == TS_UPD_DR)
         nxt = (cs == CS_SELECT) ? CS_ACCESS : CS_SELECT;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) cs <= CS_IDLE;
      else         cs <= nxt;
   end

   AST_SEQ_TLR: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_TLR) |=> (cs == CS_IDLE)); // R4

   AST_SEQ_NOEN: assert property (@(posedge tck) disable iff (!trst_n)
      (!en) |=> (cs == CS_IDLE)); // R4

   AST_SEQ_CMD2DAT: assert property (@(posedge tck) disable iff (!trst_n)
      (en && st == TS_UPD_DR && cs == CS_SELECT) |=> (cs == CS_ACCESS)); // R5

   AST_SEQ_DAT2CMD: assert property (@(posedge tck) disable iff (!trst_n)
      (en && st == TS_UPD_DR && cs == CS_ACCESS) |=> (cs == CS_SELECT)); // R6

endmodule

// File: rtl/dra_dr.sv
module dra_dr
   import dra_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tdi,
   input  tap_st_e           st,
   input  seq_st_e           cs,
   input  logic              en,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic              dr_lsb
);

   localparam int CMD_W = ADDR_W + 1;

   logic              byp_q;
   logic [CMD_W-1:0]  cmd_sh;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [DATA_W-1:0] dat_sh;
   logic              sel_cmd;
   logic              sel_dat;

   assign sel_cmd = en && (cs == CS_SELECT);
   assign sel_dat = en && (cs == CS_ACCESS);

   // bypass bit, always present
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_q <= 1'b0;
      else if (st == TS_CAP_DR)   byp_q <= 1'b0;
      else if (st == TS_SHF_DR)   byp_q <= tdi;
   end

   // command pass
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cmd_sh <= '0;
         addr_q <= '0;
         wr_q   <= 1'b0;
      end else if (sel_cmd) begin
         case (st)
            TS_CAP_DR: cmd_sh <= '0;
            TS_SHF_DR: cmd_sh <= {tdi, cmd_sh[CMD_W-1:1]};
            TS_UPD_DR: begin
               addr_q <= cmd_sh[CMD_W-1:1];
               wr_q   <= cmd_sh[0];
            end
            default: ;
         endcase
      end
   end

   // data pass
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         dat_sh <= '0;
      end else if (sel_dat) begin
         if (st == TS_CAP_DR)      dat_sh <= wr_q ? '0 : reg_rdata;
         else if (st == TS_SHF_DR) dat_sh <= {tdi, dat_sh[DATA_W-1:1]};
      end
   end

   assign reg_rd    = sel_dat && (st == TS_CAP_DR) && !wr_q;
   assign reg_wr    = sel_dat && (st == TS_UPD_DR) &&  wr_q;
   assign reg_addr  = addr_q;
   assign reg_wdata = dat_sh;
   assign dr_lsb    = sel_cmd ? cmd_sh[0] : (sel_dat ? dat_sh[0] : byp_q);

   AST_WR_PULSE: assert property (@(posedge tck) disable iff (!trst_n)
      reg_wr |=> !reg_wr); // R8

   AST_RD_PULSE: assert property (@(posedge tck) disable iff (!trst_n)
      reg_rd |=> !reg_rd); // R7

   AST_WR_ADDR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
      reg_wr |-> $stable(reg_addr)); // R8

   AST_NOEN_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      !en |-> !(reg_wr || reg_rd)); // R3

endmodule

// File: rtl/jtag_dbg_regacc.sv
module jtag_dbg_regacc
   import dra_pkg::*;
#(
   parameter int              IR_W   = 4,
   parameter logic [IR_W-1:0] EN_OP  = 4'b1000,
   parameter int              ADDR_W = 7,
   parameter int              DATA_W = 32
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam logic [IR_W-1:0] IR_BYP = '1;

   generate
      if (IR_W < 2) begin : g_chk_ir
         $error("IR_W must be at least 2");
      end
      if (EN_OP == IR_BYP) begin : g_chk_op
         $error("EN_OP must differ from the bypass opcode");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_chk_w
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   tap_st_e         st;
   seq_st_e         cs;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_lsb;
   logic            en;
   logic            tdo_q;
   logic            oe_q;

   dra_tap u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   dra_ir #(.IR_W(IR_W)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .st     (st),
      .ir_q   (ir_q),
      .ir_lsb (ir_lsb)
   );

   assign en = (ir_q == EN_OP);

   dra_seq u_seq (
      .tck    (tck),
      .trst_n (trst_n),
      .st     (st),
      .en     (en),
      .cs     (cs)
   );

   dra_dr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dr (
      .tck       (tck),
      .trst_n    (trst_n),
      .tdi       (tdi),
      .st        (st),
      .cs        (cs),
      .en        (en),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .dr_lsb    (dr_lsb)
   );

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= (st == TS_SHF_IR) || (st == TS_SHF_DR);
         if (st == TS_SHF_IR)      tdo_q <= ir_lsb;
         else if (st == TS_SHF_DR) tdo_q <= dr_lsb;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

   AST_OE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (st == TS_SHF_IR || st == TS_SHF_DR)); // R9

   AST_TDO_RISE_STABLE: assert property (@(negedge tck) disable iff (!trst_n)
      (st != TS_SHF_IR && st != TS_SHF_DR) |=> $stable(tdo)); // R9

endmodule

// File: tb/jtag_dbg_regacc_tb.sv
`timescale 1ns/1ps
module jtag_dbg_regacc_tb;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic        tdo_oe;
   logic [6:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic        reg_wr;
   logic        reg_rd;
   logic [31:0] reg_rdata;

   always #2.5 tck = ~tck;

   jtag_dbg_regacc u_dut (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .tdi       (tdi),
      .tdo       (tdo),
      .tdo_oe    (tdo_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   // register-file model
   logic [31:0] mem [128];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   assign reg_rdata = mem[reg_addr];

   always @(posedge tck) begin
      if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
   end

   int nvec = 0;
   int nerr = 0;
   bit oe_bad = 1'b0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int a);
      return (32'(a) * 32'h9E37_79B1) ^ 32'h5A0F_3C01;
   endfunction

   task automatic step(input logic m);
      @(negedge tck); #1;
      tms = m;
      @(posedge tck);
   endtask

   task automatic step_io(input logic m, input logic d, output logic b);
      @(negedge tck); #1;
      b = tdo;
      if (tdo_oe !== 1'b1) oe_bad = 1'b1;
      tms = m;
      tdi = d;
      @(posedge tck);
   endtask

   // one scan from Run-Test/Idle back to Run-Test/Idle
   task automatic scan(input bit irp, input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      step(1'b1);
      if (irp) step(1'b1);
      step(1'b0);
      step(1'b0);
      for (int i = 0; i < n; i++) begin
         logic b;
         step_io(i == n - 1, din[i], b);
         dout[i] = b;
      end
      step(1'b1);
      step(1'b0);
      @(negedge tck); #1;
   endtask

   task automatic do_write(input int a, input logic [31:0] d);
      logic [31:0] c;
      logic [31:0] x;
      int w0;
      scan(1'b0, 8, {24'd0, 7'(a), 1'b1}, c);
      chk(c[7:0] == 8'h00, "R5 command capture zero", c, 32'h0);
      w0 = wr_cnt;
      scan(1'b0, 32, d, x);
      chk(mem[a] == d, "R8 write data", mem[a], d);
      chk(wr_cnt == w0 + 1, "R8 single write strobe", 32'(wr_cnt), 32'(w0 + 1));
   endtask

   task automatic do_read(input int a, input logic [31:0] exp);
      logic [31:0] c;
      logic [31:0] x;
      int r0;
      int w0;
      scan(1'b0, 8, {24'd0, 7'(a), 1'b0}, c);
      r0 = rd_cnt;
      w0 = wr_cnt;
      scan(1'b0, 32, ~exp, x);
      chk(x == exp, "R7 read data", x, exp);
      chk(rd_cnt == r0 + 1, "R7 single read strobe", 32'(rd_cnt), 32'(r0 + 1));
      chk(wr_cnt == w0 && mem[a] == exp, "R8 read causes no write", mem[a], exp);
   endtask

   task automatic bypass_chk(input logic [7:0] d, input string tag);
      logic [31:0] x;
      int w0;
      w0 = wr_cnt;
      scan(1'b0, 8, {24'd0, d}, x);
      chk(x[7:0] == {d[6:0], 1'b0}, tag, x, {24'd0, d[6:0], 1'b0});
      chk(wr_cnt == w0, "R3 bypass no strobe", 32'(wr_cnt), 32'(w0));
   endtask

   initial begin
      logic [31:0] x;
      logic [31:0] c;
      for (int i = 0; i < 128; i++) mem[i] = '0;

      // reset
      repeat (3) @(posedge tck);
      #1 trst_n = 1'b1;
      @(negedge tck); #1;
      chk(tdo_oe == 1'b0, "R9 oe low after reset", 32'(tdo_oe), 32'h0);
      chk(!reg_wr && !reg_rd, "R8 no strobe after reset", {30'd0, reg_wr, reg_rd}, 32'h0);
      step(1'b0);

      // R2: capture pattern on IR scan (loads bypass)
      scan(1'b1, 4, 32'hF, x);
      chk(x[3:0] == 4'b0001, "R2 IR capture", x, 32'h1);
      chk(tdo_oe == 1'b0, "R9 oe low in idle", 32'(tdo_oe), 32'h0);

      // R3: bypass sweep
      for (int v = 0; v < 256; v += 37) bypass_chk(8'(v), "R3 bypass delay");

      // enable opcode
      scan(1'b1, 4, 32'h8, x);
      chk(x[3:0] == 4'b0001, "R2 IR capture second", x, 32'h1);

      // write sweep, back to back
      for (int a = 0; a < 128; a++) do_write(a, pat(a));
      // read sweep
      for (int a = 0; a < 128; a++) do_read(a, pat(a));
      chk(rd_cnt == 128, "R7 total reads", 32'(rd_cnt), 32'd128);
      chk(wr_cnt == 128, "R8 total writes", 32'(wr_cnt), 32'd128);

      // R4: Update-IR with opcode in force re-selects command pass
      scan(1'b0, 8, {24'd0, 7'd5, 1'b1}, c);
      scan(1'b1, 4, 32'h8, x);
      do_read(9, pat(9));
      chk(mem[5] == pat(5), "R4 aborted write left untouched", mem[5], pat(5));

      // R6: alternation, write then read same index
      do_write(77, 32'hDEAD_BEEF);
      do_read(77, 32'hDEAD_BEEF);

      // R1: five TMS high cycles reach reset, back to bypass
      repeat (5) step(1'b1);
      step(1'b0);
      bypass_chk(8'hC3, "R1 tms reset gives bypass");

      // R3/R4: other opcode gives bypass
      scan(1'b1, 4, 32'h8, x);
      scan(1'b1, 4, 32'h5, x);
      bypass_chk(8'h96, "R3 other opcode bypass");

      // R1: asynchronous reset mid-session
      scan(1'b1, 4, 32'h8, x);
      @(negedge tck); #1;
      tms = 1'b1;
      trst_n = 1'b0;
      #2 trst_n = 1'b1;
      step(1'b0);
      bypass_chk(8'h5A, "R1 trst gives bypass");

      chk(oe_bad == 1'b0, "R9 oe high during shifts", 32'(oe_bad), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!done) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

endmodule